// File: doc/BRIEF.md
# LCD Controller Bring-Up Sequencer

This block brings a small serial-attached LCD controller from reset to a state where it accepts pixel-memory writes. It never shifts bits itself. Instead it asks a separate register engine for one transaction at a time and waits for that engine to report completion. After reset it reads the controller's identification register and compares it with an expected code under a mask. If the code is wrong, the block parks in a no-device state. If it matches, the block reads the status word and then walks a step table. The table holds configuration writes, power-control writes and settle waits of 10 ms or 40 ms. The last step selects the pixel-memory register without sending a value.

Once bring-up finishes, the block follows a power request level. A change of that level to a state the display is not in runs the power-on or the power-off subsequence from the same table. The reported power state moves only when every transaction of the subsequence came back clean. Otherwise the block raises an error flag. Wait lengths are built from a parameter giving the number of clock cycles per millisecond.

Top module: `lcd_bringup_seq`

## Requirements
- R1: While reset is held, `eng_req`, `ready`, `no_dev`, `pwr_on` and `err` are 0. The first transaction after reset is a register read (`eng_op` = 2) of address 0x00, with `busy` = 1.
- R2: If the value read from address 0x00, ANDed with `ID_MASK` (0xFFF0), differs from `ID_VALUE` (0x9220), `no_dev` becomes 1 and no further transaction is ever issued. A value of 0x9221 is accepted.
- R3: After an accepted ID, a status read (`eng_op` = 3) is the next transaction, and it comes before any write.
- R4: Bring-up issues register writes (`eng_op` = 0) in this order:
  - 0x00=0x0001, then a 10 ms wait;
  - 0x01=0x691B, 0x02=0x0700, 0x03=0x1030, 0x04=0, 0x05=0, 0x07=0x0037, 0x08=0x0202, 0x09=0, 0x0B=0, 0x0C=0x0110;
  - the power-on subsequence;
  - 0x30..0x39 with 0302, 0407, 0304, 0203, 0706, 0407, 0706, 0000, 0C06, 0F00;
  - 0x21=0, 0x40=0, 0x41=0, 0x42=0xDB00, 0x43=0xDB00, 0x44=0xAF00, 0x45=0xDB00.
- R5: Each wait starts after the done of the preceding write. It lengthens the cycle gap from that done to the next request by exactly 10 or 40 times `TICKS_PER_MS`, compared with back-to-back writes.
- R6: The last bring-up transaction is an index-only write (`eng_op` = 1) of address 0x22. After it, `ready` = 1 and `pwr_on` = 0.
- R7: The power-on subsequence is run when `pwr_req` rises to 1 while the display is off, and it sets `pwr_on` to 1. Its steps are:
  - 0x10=0, wait 10 ms;
  - 0x11=0, 0x12=0, wait 40 ms;
  - 0x13=0, wait 40 ms;
  - 0x56=0x080F, 0x10=0x4240, wait 10 ms;
  - 0x11=0, 0x12=0x0014, wait 40 ms;
  - 0x13=0x1319, wait 40 ms.
- R8: The power-off subsequence is run when `pwr_req` falls to 0 while the display is on, and it clears `pwr_on`. Its steps are:
  - 0x10=0, wait 10 ms;
  - 0x11=0, 0x12=0, wait 40 ms;
  - 0x13=0, wait 40 ms.
- R9: A `pwr_req` level equal to the current power state starts no transaction.
- R10: If any transaction of a power subsequence returns `eng_err`, the subsequence still completes. At its end `err` = 1 and `pwr_on` is unchanged, and the same request is not retried until `pwr_req` changes. A later clean subsequence clears `err`.
- R11: A request keeps `eng_op`, `eng_addr` and `eng_wdata` stable until `eng_done`, and `eng_req` is low in the cycle after `eng_done`.
- R12: An engine error on the ID read also yields `no_dev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | Requested display power level (1 = on) |
| eng_req | output | 1 | Transaction request to the register engine, held until done |
| eng_op | output | 2 | 0 register write, 1 index-only write, 2 register read, 3 status read |
| eng_addr | output | 8 | Register address |
| eng_wdata | output | 16 | Value for a register write |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_err | input | 1 | Engine error, valid with eng_done |
| eng_rdata | input | 16 | Read data, valid with eng_done |
| ready | output | 1 | Bring-up finished and no sequence running |
| no_dev | output | 1 | ID check failed; sequencer stopped |
| busy | output | 1 | A probe, bring-up or power sequence is in progress |
| pwr_on | output | 1 | Current display power state |
| err | output | 1 | Last completed sequence saw an engine error |

## Verification
The bench builds the block with `TICKS_PER_MS` = 3, so a 10 ms wait is 30 cycles and a 40 ms wait is 120 cycles. This keeps the full bring-up and several power cycles within a few thousand clocks. It also lets the exact gap before each wait-delayed write be compared with the back-to-back gap. The ID parameters keep their default values, so a low-nibble variant of the ID is accepted, while a code differing above the mask and an engine error on the ID read both reach the no-device state.

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq #(
  parameter int          TICKS_PER_MS = 50000,
  parameter logic [15:0] ID_VALUE     = 16'h9220,
  parameter logic [15:0] ID_MASK      = 16'hFFF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_req,
  output logic        eng_req,
  output logic [1:0]  eng_op,
  output logic [7:0]  eng_addr,
  output logic [15:0] eng_wdata,
  input  logic        eng_done,
  input  logic        eng_err,
  input  logic [15:0] eng_rdata,
  output logic        ready,
  output logic        no_dev,
  output logic        busy,
  output logic        pwr_on,
  output logic        err
);

  localparam int W10 = 10 * TICKS_PER_MS;
  localparam int W40 = 40 * TICKS_PER_MS;
  localparam int TW  = $clog2(W40);

  localparam logic [2:0] OP_WR  = 3'd0;
  localparam logic [2:0] OP_IX  = 3'd1;
  localparam logic [2:0] OP_W10 = 3'd2;
  localparam logic [2:0] OP_W40 = 3'd3;
  localparam logic [2:0] OP_END = 3'd4;

  localparam logic [5:0] PC_PON   = 6'd0;
  localparam logic [5:0] PC_POFF  = 6'd16;
  localparam logic [5:0] PC_INITA = 6'd24;
  localparam logic [5:0] PC_INITC = 6'd37;

  typedef enum logic [2:0] {S_BOOT, S_XFER, S_RUN, S_WAIT, S_IDLE, S_DEAD} state_t;
  typedef enum logic [2:0] {P_ID, P_STAT, P_INITA, P_INITPON, P_INITC, P_PON, P_POFF} phase_t;

  function automatic logic [26:0] step(input logic [5:0] a);
    case (a)
      6'd0:  step = {OP_WR,  8'h10, 16'h0000};
      6'd1:  step = {OP_W10, 8'h00, 16'h0000};
      6'd2:  step = {OP_WR,  8'h11, 16'h0000};
      6'd3:  step = {OP_WR,  8'h12, 16'h0000};
      6'd4:  step = {OP_W40, 8'h00, 16'h0000};
      6'd5:  step = {OP_WR,  8'h13, 16'h0000};
      6'd6:  step = {OP_W40, 8'h00, 16'h0000};
      6'd7:  step = {OP_WR,  8'h56, 16'h080F};
      6'd8:  step = {OP_WR,  8'h10, 16'h4240};
      6'd9:  step = {OP_W10, 8'h00, 16'h0000};
      6'd10: step = {OP_WR,  8'h11, 16'h0000};
      6'd11: step = {OP_WR,  8'h12, 16'h0014};
      6'd12: step = {OP_W40, 8'h00, 16'h0000};
      6'd13: step = {OP_WR,  8'h13, 16'h1319};
      6'd14: step = {OP_W40, 8'h00, 16'h0000};
      6'd15: step = {OP_END, 8'h00, 16'h0000};
      6'd16: step = {OP_WR,  8'h10, 16'h0000};
      6'd17: step = {OP_W10, 8'h00, 16'h0000};
      6'd18: step = {OP_WR,  8'h11, 16'h0000};
      6'd19: step = {OP_WR,  8'h12, 16'h0000};
      6'd20: step = {OP_W40, 8'h00, 16'h0000};
      6'd21: step = {OP_WR,  8'h13, 16'h0000};
      6'd22: step = {OP_W40, 8'h00, 16'h0000};
      6'd23: step = {OP_END, 8'h00, 16'h0000};
      6'd24: step = {OP_WR,  8'h00, 16'h0001};
      6'd25: step = {OP_W10, 8'h00, 16'h0000};
      6'd26: step = {OP_WR,  8'h01, 16'h691B};
      6'd27: step = {OP_WR,  8'h02, 16'h0700};
      6'd28: step = {OP_WR,  8'h03, 16'h1030};
      6'd29: step = {OP_WR,  8'h04, 16'h0000};
      6'd30: step = {OP_WR,  8'h05, 16'h0000};
      6'd31: step = {OP_WR,  8'h07, 16'h0037};
      6'd32: step = {OP_WR,  8'h08, 16'h0202};
      6'd33: step = {OP_WR,  8'h09, 16'h0000};
      6'd34: step = {OP_WR,  8'h0B, 16'h0000};
      6'd35: step = {OP_WR,  8'h0C, 16'h0110};
      6'd36: step = {OP_END, 8'h00, 16'h0000};
      6'd37: step = {OP_WR,  8'h30, 16'h0302};
      6'd38: step = {OP_WR,  8'h31, 16'h0407};
      6'd39: step = {OP_WR,  8'h32, 16'h0304};
      6'd40: step = {OP_WR,  8'h33, 16'h0203};
      6'd41: step = {OP_WR,  8'h34, 16'h0706};
      6'd42: step = {OP_WR,  8'h35, 16'h0407};
      6'd43: step = {OP_WR,  8'h36, 16'h0706};
      6'd44: step = {OP_WR,  8'h37, 16'h0000};
      6'd45: step = {OP_WR,  8'h38, 16'h0C06};
      6'd46: step = {OP_WR,  8'h39, 16'h0F00};
      6'd47: step = {OP_WR,  8'h21, 16'h0000};
      6'd48: step = {OP_WR,  8'h40, 16'h0000};
      6'd49: step = {OP_WR,  8'h41, 16'h0000};
      6'd50: step = {OP_WR,  8'h42, 16'hDB00};
      6'd51: step = {OP_WR,  8'h43, 16'hDB00};
      6'd52: step = {OP_WR,  8'h44, 16'hAF00};
      6'd53: step = {OP_WR,  8'h45, 16'hDB00};
      6'd54: step = {OP_IX,  8'h22, 16'h0000};
      default: step = {OP_END, 8'h00, 16'h0000};
    endcase
  endfunction

  state_t          st;
  phase_t          ph;
  logic [5:0]      pc;
  logic [TW-1:0]   tmr;
  logic            run_err;
  logic            tried;
  logic [26:0]     cur;

  assign cur     = step(pc);
  assign eng_req = (st == S_XFER);
  assign ready   = (st == S_IDLE);
  assign no_dev  = (st == S_DEAD);
  assign busy    = (st == S_BOOT) || (st == S_XFER) || (st == S_RUN) || (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_BOOT;
      ph        <= P_ID;
      pc        <= '0;
      tmr       <= '0;
      eng_op    <= 2'd2;
      eng_addr  <= 8'h00;
      eng_wdata <= 16'h0000;
      run_err   <= 1'b0;
      err       <= 1'b0;
      pwr_on    <= 1'b0;
      tried     <= 1'b0;
    end else begin
      case (st)
        S_BOOT: st <= S_XFER;
        S_XFER: if (eng_done) begin
          case (ph)
            P_ID: begin
              if (eng_err || ((eng_rdata & ID_MASK) != ID_VALUE)) st <= S_DEAD;
              else begin
                ph <= P_STAT;
                st <= S_RUN;
              end
            end
            P_STAT: begin
              if (eng_err) run_err <= 1'b1;
              ph <= P_INITA;
              pc <= PC_INITA;
              st <= S_RUN;
            end
            default: begin
              if (eng_err) run_err <= 1'b1;
              pc <= pc + 6'd1;
              st <= S_RUN;
            end
          endcase
        end
        S_RUN: begin
          if (ph == P_STAT) begin
            eng_op    <= 2'd3;
            eng_addr  <= 8'h00;
            eng_wdata <= 16'h0000;
            st        <= S_XFER;
          end else begin
            case (cur[26:24])
              OP_WR, OP_IX: begin
                eng_op    <= (cur[26:24] == OP_WR) ? 2'd0 : 2'd1;
                eng_addr  <= cur[23:16];
                eng_wdata <= cur[15:0];
                st        <= S_XFER;
              end
              OP_W10: begin
                tmr <= TW'(W10 - 2);
                st  <= S_WAIT;
              end
              OP_W40: begin
                tmr <= TW'(W40 - 2);
                st  <= S_WAIT;
              end
              default: begin
                case (ph)
                  P_INITA: begin
                    ph <= P_INITPON;
                    pc <= PC_PON;
                  end
                  P_INITPON: begin
                    ph <= P_INITC;
                    pc <= PC_INITC;
                  end
                  P_INITC: begin
                    err <= run_err;
                    st  <= S_IDLE;
                  end
                  default: begin
                    err <= run_err;
                    if (!run_err) pwr_on <= tried;
                    st  <= S_IDLE;
                  end
                endcase
              end
            endcase
          end
        end
        S_WAIT: begin
          if (tmr == '0) begin
            pc <= pc + 6'd1;
            st <= S_RUN;
          end else tmr <= tmr - 1'b1;
        end
        S_IDLE: if (pwr_req != tried) begin
          tried <= pwr_req;
          if (pwr_req != pwr_on) begin
            run_err <= 1'b0;
            ph      <= pwr_req ? P_PON : P_POFF;
            pc      <= pwr_req ? PC_PON : PC_POFF;
            st      <= S_RUN;
          end
        end
        default: st <= S_DEAD;
      endcase
    end
  end

endmodule

// File: rtl/lcd_bringup_seq_chk.sv
module lcd_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_req,
  input logic        eng_req,
  input logic [1:0]  eng_op,
  input logic [7:0]  eng_addr,
  input logic [15:0] eng_wdata,
  input logic        eng_done,
  input logic        ready,
  input logic        no_dev,
  input logic        busy,
  input logic        pwr_on
);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_addr) && $stable(eng_wdata));

  a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done |=> !eng_req);

  a_r2_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    no_dev |=> no_dev && !eng_req);

  a_r10_pwr_at_run_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_on) |-> $past(busy));

  a_r9_same_level: assert property (@(posedge clk) disable iff (!rst_n)
    ready && (pwr_req == pwr_on) |=> !eng_req);

endmodule

bind lcd_bringup_seq lcd_bringup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .eng_req(eng_req), .eng_op(eng_op),
  .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_done(eng_done), .ready(ready),
  .no_dev(no_dev), .busy(busy), .pwr_on(pwr_on)
);

// File: tb/tb_lcd_bringup_seq.sv
module tb_lcd_bringup_seq;
  localparam int TPM = 3;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0, pwr_req = 1'b0;
  logic eng_req, ready, no_dev, busy, pwr_on, err;
  logic [1:0] eng_op;
  logic [7:0] eng_addr;
  logic [15:0] eng_wdata;
  logic eng_done = 1'b0, eng_err = 1'b0;
  logic [15:0] eng_rdata = 16'h0;

  lcd_bringup_seq #(.TICKS_PER_MS(TPM)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .eng_req(eng_req), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_err(eng_err),
    .eng_rdata(eng_rdata), .ready(ready), .no_dev(no_dev), .busy(busy), .pwr_on(pwr_on),
    .err(err));

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [15:0] id_val = 16'h9221;
  int err_at = -1;
  int nlog = 0, ncnt = 0, last_done = 0, cnt = 0, viol = 0;
  bit inreq = 0;
  logic [1:0] lop [256];
  logic [7:0] laddr [256];
  logic [15:0] ldat [256];
  int lgap [256];
  logic [1:0] eop [64];
  logic [7:0] eaddr [64];
  logic [15:0] edat [64];
  int ne = 0;

  initial forever begin
    @(negedge clk);
    ncnt++;
    if (!rst_n) begin
      eng_done = 0; eng_err = 0; inreq = 0; cnt = 0; last_done = ncnt;
    end else if (eng_done) begin
      eng_done = 0; eng_err = 0;
      if (eng_req) viol++;
    end else if (eng_req) begin
      if (!inreq) begin
        inreq = 1; cnt = 0;
        if (nlog < 256) begin
          lop[nlog] = eng_op; laddr[nlog] = eng_addr; ldat[nlog] = eng_wdata;
          lgap[nlog] = ncnt - last_done;
        end
      end else if (nlog < 256) begin
        if (lop[nlog] != eng_op || laddr[nlog] != eng_addr || ldat[nlog] != eng_wdata) viol++;
      end
      cnt++;
      if (cnt >= LAT) begin
        eng_done = 1;
        eng_err = (nlog == err_at);
        eng_rdata = (eng_op == 2'd2) ? id_val : 16'h0000;
        last_done = ncnt; inreq = 0; nlog++;
      end
    end
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic e_add(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    eop[ne] = op; eaddr[ne] = a; edat[ne] = d; ne++;
  endtask

  task automatic exp_pon();
    e_add(0, 8'h10, 16'h0000); e_add(0, 8'h11, 16'h0000); e_add(0, 8'h12, 16'h0000);
    e_add(0, 8'h13, 16'h0000); e_add(0, 8'h56, 16'h080F); e_add(0, 8'h10, 16'h4240);
    e_add(0, 8'h11, 16'h0000); e_add(0, 8'h12, 16'h0014); e_add(0, 8'h13, 16'h1319);
  endtask

  task automatic exp_poff();
    e_add(0, 8'h10, 16'h0000); e_add(0, 8'h11, 16'h0000); e_add(0, 8'h12, 16'h0000);
    e_add(0, 8'h13, 16'h0000);
  endtask

  task automatic chk_seq(input string req, input int base);
    int bad = -1;
    chk_eq(req, "transaction count", nlog - base, ne);
    for (int i = 0; i < ne && base + i < nlog; i++) begin
      if (bad < 0 && (lop[base+i] != eop[i] || laddr[base+i] != eaddr[i] ||
          (eop[i] == 2'd0 && ldat[base+i] != edat[i]))) bad = i;
    end
    chk_eq(req, "first mismatching step", bad, -1);
  endtask

  task automatic wait_settle();
    int k = 0;
    repeat (3) @(negedge clk);
    while (!ready && !no_dev && k < 20000) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic do_reset(input logic [15:0] id, input int inject);
    rst_n = 0; pwr_req = 0; id_val = id; err_at = inject;
    repeat (3) @(negedge clk);
    nlog = 0;
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    rst_n = 0; pwr_req = 0; id_val = 16'h9221; err_at = -1;
    repeat (3) @(negedge clk);
    chk_eq("R1", "eng_req in reset", eng_req, 0);
    chk_eq("R1", "ready/no_dev/pwr_on/err in reset", {ready, no_dev, pwr_on, err}, 0);
    nlog = 0;
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk_eq("R1", "busy after reset", busy, 1);
  endtask

  task automatic t_bringup();
    wait_settle();
    chk_eq("R6", "ready after bring-up", ready, 1);
    chk_eq("R6", "pwr_on after bring-up", pwr_on, 0);
    chk_eq("R1", "first op", lop[0], 2);
    chk_eq("R1", "first address", laddr[0], 0);
    chk_eq("R3", "second op is status read", lop[1], 3);
    ne = 0;
    e_add(2, 8'h00, 0); e_add(3, 8'h00, 0);
    e_add(0, 8'h00, 16'h0001); e_add(0, 8'h01, 16'h691B); e_add(0, 8'h02, 16'h0700);
    e_add(0, 8'h03, 16'h1030); e_add(0, 8'h04, 16'h0000); e_add(0, 8'h05, 16'h0000);
    e_add(0, 8'h07, 16'h0037); e_add(0, 8'h08, 16'h0202); e_add(0, 8'h09, 16'h0000);
    e_add(0, 8'h0B, 16'h0000); e_add(0, 8'h0C, 16'h0110);
    exp_pon();
    e_add(0, 8'h30, 16'h0302); e_add(0, 8'h31, 16'h0407); e_add(0, 8'h32, 16'h0304);
    e_add(0, 8'h33, 16'h0203); e_add(0, 8'h34, 16'h0706); e_add(0, 8'h35, 16'h0407);
    e_add(0, 8'h36, 16'h0706); e_add(0, 8'h37, 16'h0000); e_add(0, 8'h38, 16'h0C06);
    e_add(0, 8'h39, 16'h0F00); e_add(0, 8'h21, 16'h0000); e_add(0, 8'h40, 16'h0000);
    e_add(0, 8'h41, 16'h0000); e_add(0, 8'h42, 16'hDB00); e_add(0, 8'h43, 16'hDB00);
    e_add(0, 8'h44, 16'hAF00); e_add(0, 8'h45, 16'hDB00);
    e_add(1, 8'h22, 0);
    chk_seq("R4", 0);
    chk_eq("R6", "last op index-only", lop[nlog-1], 1);
    chk_eq("R6", "last address", laddr[nlog-1], 8'h22);
    chk_eq("R5", "back-to-back gap", lgap[4], 2);
    chk_eq("R5", "gap after 10 ms wait", lgap[3], 2 + 10*TPM);
    chk_eq("R5", "gap after 40 ms wait in bring-up", lgap[16], 2 + 40*TPM);
  endtask

  task automatic t_power_on();
    int base = nlog;
    pwr_req = 1;
    wait_settle();
    ne = 0; exp_pon();
    chk_seq("R7", base);
    chk_eq("R7", "pwr_on", pwr_on, 1);
    chk_eq("R7", "err", err, 0);
    chk_eq("R5", "gap after 10 ms wait", lgap[base+1], 2 + 10*TPM);
  endtask

  task automatic t_hold();
    int base = nlog;
    repeat (100) @(negedge clk);
    chk_eq("R9", "no transaction on held level", nlog - base, 0);
    chk_eq("R9", "still ready", ready, 1);
  endtask

  task automatic t_power_off();
    int base = nlog;
    pwr_req = 0;
    wait_settle();
    ne = 0; exp_poff();
    chk_seq("R8", base);
    chk_eq("R8", "pwr_on", pwr_on, 0);
    chk_eq("R5", "gap after 40 ms wait in power-off", lgap[base+3], 2 + 40*TPM);
  endtask

  task automatic t_engine_error();
    int base = nlog;
    err_at = base + 1;
    pwr_req = 1;
    wait_settle();
    chk_eq("R10", "subsequence completes", nlog - base, 9);
    chk_eq("R10", "err raised", err, 1);
    chk_eq("R10", "pwr_on unchanged", pwr_on, 0);
    err_at = -1;
    repeat (300) @(negedge clk);
    chk_eq("R10", "no retry while level held", nlog - base, 9);
    pwr_req = 0;
    repeat (50) @(negedge clk);
    chk_eq("R9", "return to current state is silent", nlog - base, 9);
    base = nlog;
    pwr_req = 1;
    wait_settle();
    chk_eq("R10", "clean retry count", nlog - base, 9);
    chk_eq("R10", "err cleared", err, 0);
    chk_eq("R10", "pwr_on after clean run", pwr_on, 1);
  endtask

  task automatic t_bad_id();
    do_reset(16'h9310, -1);
    wait_settle();
    chk_eq("R2", "no_dev on wrong ID", no_dev, 1);
    chk_eq("R2", "ready stays low", ready, 0);
    repeat (50) @(negedge clk);
    chk_eq("R2", "only the ID read issued", nlog, 1);
  endtask

  task automatic t_id_error();
    do_reset(16'h9220, 0);
    wait_settle();
    chk_eq("R12", "no_dev on ID read error", no_dev, 1);
    chk_eq("R12", "only the ID read issued", nlog, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_bringup();
    t_power_on();
    t_hold();
    t_power_off();
    t_engine_error();
    chk_eq("R11", "request held until done and dropped after", viol, 0);
    t_bad_id();
    t_id_error();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule